// File: doc/BRIEF.md
# Legacy A20 Gate Controller

This block produces the address-line-20 gate signal of a PC-compatible keyboard controller. It watches the host I/O write bus. A command byte on the command port, followed by a byte on the data port, loads the gate from that data byte, and the hardware handles this pair without firmware. The embedded firmware can also force the gate. It has a set strobe and a clear strobe, and both act whatever data comes with them. It can also write the gate directly and read it back.

A separate system-control port holds a second gate bit. That bit only reaches the output while an enable input is high. The output gate is the OR of the latched keyboard-controller gate and the enabled system-control bit. A data-port write also raises the input-buffer-full flag, and firmware clears that flag with a strobe.

Top module: `a20_gate_ctl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the armed state, the latched gate, the system-control bit and the input-buffer-full flag. After it, `gate_out`, `ibf` and `gate_rd_data` are all 0.
- R2: A host write (`host_wr` high, `host_aen` low) of 0xD1 to address 0x64 arms the sequence. The next host write to address 0x60 loads the latched gate from bit 1 of its data and disarms. Later data-port writes leave the gate unchanged.
- R3: A host data-port write while not armed leaves the latched gate unchanged.
- R4: A host command-port write of any value other than 0xD1, 0xFF or 0xFE cancels the armed state.
- R5: Host command-port writes of 0xFF or 0xFE leave the armed state exactly as it was.
- R6: A host write with `host_aen` high has no effect on any state.
- R7: `fw_set_wr` makes the latched gate 1 and `fw_clr_wr` makes it 0, whatever data is present. In one cycle the clear takes precedence over the set. Both take precedence over a firmware gate write and over a host-sequence load.
- R8: `fw_gate_wr` loads the latched gate from bit 0 of `fw_gate_wdata`. It takes precedence over a host-sequence load in the same cycle.
- R9: A host write to address 0x92 stores bit 1 of its data as the system-control bit. `gate_out` equals the latched gate OR (`p92_en` AND the system-control bit), and it changes in the cycle after the register write.
- R10: `gate_rd_data` carries `gate_out` on bit 0 and zero on every other bit.
- R11: A host data-port write sets `ibf`. `fw_ibf_clr` clears it, and the set takes precedence when both occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host I/O write strobe, one cycle per write |
| host_aen | input | 1 | Address enable; a write is decoded only while this is low |
| host_addr | input | ADDR_W | Host I/O address |
| host_wdata | input | DATA_W | Host write data |
| fw_set_wr | input | 1 | Firmware write to the gate-set register |
| fw_clr_wr | input | 1 | Firmware write to the gate-clear register |
| fw_gate_wr | input | 1 | Firmware write to the gate register |
| fw_gate_wdata | input | DATA_W | Firmware gate register write data (bit 0 used) |
| fw_ibf_clr | input | 1 | Firmware clears the input-buffer-full flag |
| p92_en | input | 1 | Lets the system-control bit reach the gate output |
| gate_out | output | 1 | A20 gate output |
| gate_rd_data | output | DATA_W | Gate register read value |
| ibf | output | 1 | Input-buffer-full flag |

## Verification
On every cycle the assertions check these rules:
- the set and clear strobes act with clear taking precedence;
- a qualified 0xD1 command arms the sequence;
- null commands keep the arm unchanged;
- data writes raise the flag;
- the enabled system-control bit pulls the gate high;
- unqualified writes and idle firmware leave every state register unchanged.

The cases that depend on history need the bench's scenarios. These include a second data write after the gate load, a cancel followed by a data write, and arming across interleaved 0xFF/0xFE writes. Precedence collisions where firmware and host act in the same cycle are also covered by the scenarios. The bench compares against a model built from the requirements.

// File: rtl/a20_pkg.sv
package a20_pkg;

   // Classification of one qualified host write
   typedef enum logic [2:0] {
      EV_NONE      = 3'd0,
      EV_CMD_ARM   = 3'd1,
      EV_CMD_NULL  = 3'd2,
      EV_CMD_OTHER = 3'd3,
      EV_DATA      = 3'd4,
      EV_SYSCTL    = 3'd5
   } host_ev_e;

endpackage

// File: rtl/a20_host_decode.sv
module a20_host_decode
   import a20_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter logic [ADDR_W-1:0] CMD_ADDR    = 'h64,
   parameter logic [ADDR_W-1:0] DATA_ADDR   = 'h60,
   parameter logic [ADDR_W-1:0] SYSCTL_ADDR = 'h92,
   parameter logic [DATA_W-1:0] ARM_CODE    = 'hD1,
   parameter logic [DATA_W-1:0] NULL_CODE_A = 'hFF,
   parameter logic [DATA_W-1:0] NULL_CODE_B = 'hFE
) (
   input  logic              host_wr,
   input  logic              host_aen,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output host_ev_e          ev
);

   logic qual;
   assign qual = host_wr & ~host_aen;

   always_comb begin
      ev = EV_NONE;
      if (qual) begin
         if (host_addr == CMD_ADDR) begin
            if (host_wdata == ARM_CODE)
               ev = EV_CMD_ARM;
            else if ((host_wdata == NULL_CODE_A) || (host_wdata == NULL_CODE_B))
               ev = EV_CMD_NULL;
            else
               ev = EV_CMD_OTHER;
         end else if (host_addr == DATA_ADDR) begin
            ev = EV_DATA;
         end else if (host_addr == SYSCTL_ADDR) begin
            ev = EV_SYSCTL;
         end
      end
   end

endmodule

// File: rtl/a20_kbc_seq.sv
module a20_kbc_seq
   import a20_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  host_ev_e ev,
   input  logic     host_gate_bit,
   input  logic     fw_set_wr,
   input  logic     fw_clr_wr,
   input  logic     fw_gate_wr,
   input  logic     fw_gate_bit,
   input  logic     fw_ibf_clr,
   output logic     armed,
   output logic     kbc_gate,
   output logic     ibf
);

   logic armed_q, gate_q, ibf_q;
   logic host_load;

   assign host_load = (ev == EV_DATA) && armed_q;

   // arm tracking: null codes keep state, other commands cancel
   always_ff @(posedge clk) begin
      if (rst) begin
         armed_q <= 1'b0;
      end else begin
         unique case (ev)
            EV_CMD_ARM:   armed_q <= 1'b1;
            EV_CMD_OTHER: armed_q <= 1'b0;
            EV_DATA:      armed_q <= 1'b0;
            default:      armed_q <= armed_q;
         endcase
      end
   end

   // latched gate with fixed precedence
   always_ff @(posedge clk) begin
      if (rst)
         gate_q <= 1'b0;
      else if (fw_clr_wr)
         gate_q <= 1'b0;
      else if (fw_set_wr)
         gate_q <= 1'b1;
      else if (fw_gate_wr)
         gate_q <= fw_gate_bit;
      else if (host_load)
         gate_q <= host_gate_bit;
   end

   always_ff @(posedge clk) begin
      if (rst)
         ibf_q <= 1'b0;
      else if (ev == EV_DATA)
         ibf_q <= 1'b1;
      else if (fw_ibf_clr)
         ibf_q <= 1'b0;
   end

   assign armed    = armed_q;
   assign kbc_gate = gate_q;
   assign ibf      = ibf_q;

endmodule

// File: rtl/a20_sysctl.sv
module a20_sysctl
   import a20_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  host_ev_e ev,
   input  logic     wbit,
   output logic     sys_gate
);

   logic q;

   always_ff @(posedge clk) begin
      if (rst)
         q <= 1'b0;
      else if (ev == EV_SYSCTL)
         q <= wbit;
   end

   assign sys_gate = q;

endmodule

// File: rtl/a20_gate_ctl.sv
module a20_gate_ctl
   import a20_pkg::*;
#(
   parameter int unsigned ADDR_W          = 16,
   parameter int unsigned DATA_W          = 8,
   parameter logic [ADDR_W-1:0] CMD_ADDR    = 'h64,
   parameter logic [ADDR_W-1:0] DATA_ADDR   = 'h60,
   parameter logic [ADDR_W-1:0] SYSCTL_ADDR = 'h92,
   parameter logic [DATA_W-1:0] ARM_CODE    = 'hD1,
   parameter logic [DATA_W-1:0] NULL_CODE_A = 'hFF,
   parameter logic [DATA_W-1:0] NULL_CODE_B = 'hFE,
   parameter int unsigned HOST_GATE_BIT   = 1,
   parameter int unsigned SYSCTL_GATE_BIT = 1,
   parameter int unsigned FW_GATE_BIT     = 0,
   parameter bit          OUT_REG         = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              host_wr,
   input  logic              host_aen,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              fw_set_wr,
   input  logic              fw_clr_wr,
   input  logic              fw_gate_wr,
   input  logic [DATA_W-1:0] fw_gate_wdata,
   input  logic              fw_ibf_clr,
   input  logic              p92_en,
   output logic              gate_out,
   output logic [DATA_W-1:0] gate_rd_data,
   output logic              ibf
);

   localparam int unsigned RD_PAD_W = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_dw
      $error("a20_gate_ctl: DATA_W must be at least 2");
   end
   if (HOST_GATE_BIT >= DATA_W || SYSCTL_GATE_BIT >= DATA_W || FW_GATE_BIT >= DATA_W) begin : g_bad_bit
      $error("a20_gate_ctl: gate bit index outside data width");
   end
   if (CMD_ADDR == DATA_ADDR || CMD_ADDR == SYSCTL_ADDR || DATA_ADDR == SYSCTL_ADDR) begin : g_bad_addr
      $error("a20_gate_ctl: port addresses must differ");
   end

   host_ev_e ev;
   logic     armed_q;
   logic     kbc_gate_q;
   logic     sys_gate_q;
   logic     gate_comb;

   a20_host_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR), .SYSCTL_ADDR(SYSCTL_ADDR),
      .ARM_CODE(ARM_CODE), .NULL_CODE_A(NULL_CODE_A), .NULL_CODE_B(NULL_CODE_B)
   ) u_dec (
      .host_wr(host_wr), .host_aen(host_aen),
      .host_addr(host_addr), .host_wdata(host_wdata), .ev(ev)
   );

   a20_kbc_seq u_seq (
      .clk(clk), .rst(rst), .ev(ev),
      .host_gate_bit(host_wdata[HOST_GATE_BIT]),
      .fw_set_wr(fw_set_wr), .fw_clr_wr(fw_clr_wr),
      .fw_gate_wr(fw_gate_wr), .fw_gate_bit(fw_gate_wdata[FW_GATE_BIT]),
      .fw_ibf_clr(fw_ibf_clr),
      .armed(armed_q), .kbc_gate(kbc_gate_q), .ibf(ibf)
   );

   a20_sysctl u_sys (
      .clk(clk), .rst(rst), .ev(ev),
      .wbit(host_wdata[SYSCTL_GATE_BIT]), .sys_gate(sys_gate_q)
   );

   assign gate_comb = kbc_gate_q | (p92_en & sys_gate_q);

   if (OUT_REG) begin : g_out_reg
      logic gate_r;
      always_ff @(posedge clk) begin
         if (rst) gate_r <= 1'b0;
         else     gate_r <= gate_comb;
      end
      assign gate_out = gate_r;
   end else begin : g_out_comb
      assign gate_out = gate_comb;
   end

   assign gate_rd_data = {{RD_PAD_W{1'b0}}, gate_out};

endmodule

// File: rtl/a20_gate_ctl_chk.sv
module a20_gate_ctl_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter logic [ADDR_W-1:0] CMD_ADDR  = 'h64,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 'h60,
   parameter logic [DATA_W-1:0] ARM_CODE  = 'hD1,
   parameter logic [DATA_W-1:0] NULL_CODE_A = 'hFF,
   parameter logic [DATA_W-1:0] NULL_CODE_B = 'hFE,
   parameter bit OUT_REG = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              host_wr,
   input logic              host_aen,
   input logic [ADDR_W-1:0] host_addr,
   input logic [DATA_W-1:0] host_wdata,
   input logic              fw_set_wr,
   input logic              fw_clr_wr,
   input logic              fw_gate_wr,
   input logic              fw_ibf_clr,
   input logic              p92_en,
   input logic              armed,
   input logic              kbc_gate,
   input logic              sys_gate,
   input logic              ibf,
   input logic              gate_out
);

   logic q_wr, cmd_wr, data_wr, fw_idle;
   assign q_wr    = host_wr & ~host_aen;
   assign cmd_wr  = q_wr && (host_addr == CMD_ADDR);
   assign data_wr = q_wr && (host_addr == DATA_ADDR);
   assign fw_idle = !fw_set_wr && !fw_clr_wr && !fw_gate_wr && !fw_ibf_clr;

   a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
      fw_clr_wr |=> !kbc_gate);

   a_r7_set_forces: assert property (@(posedge clk) disable iff (rst)
      (fw_set_wr && !fw_clr_wr) |=> kbc_gate);

   a_r2_arm: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && host_wdata == ARM_CODE) |=> armed);

   a_r5_null_keeps_arm: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && (host_wdata == NULL_CODE_A || host_wdata == NULL_CODE_B))
         |=> (armed == $past(armed)));

   a_r11_ibf_set: assert property (@(posedge clk) disable iff (rst)
      data_wr |=> ibf);

   a_r6_unqualified_idle: assert property (@(posedge clk) disable iff (rst)
      (!q_wr && fw_idle) |=> ($stable(kbc_gate) && $stable(armed) && $stable(ibf) && $stable(sys_gate)));

   if (!OUT_REG) begin : g_comb_chk
      a_r9_sysctl_path: assert property (@(posedge clk) disable iff (rst)
         (p92_en && sys_gate) |-> gate_out);
   end

endmodule

bind a20_gate_ctl a20_gate_ctl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR),
   .ARM_CODE(ARM_CODE), .NULL_CODE_A(NULL_CODE_A), .NULL_CODE_B(NULL_CODE_B),
   .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst(rst), .host_wr(host_wr), .host_aen(host_aen),
   .host_addr(host_addr), .host_wdata(host_wdata),
   .fw_set_wr(fw_set_wr), .fw_clr_wr(fw_clr_wr), .fw_gate_wr(fw_gate_wr),
   .fw_ibf_clr(fw_ibf_clr), .p92_en(p92_en),
   .armed(armed_q), .kbc_gate(kbc_gate_q), .sys_gate(sys_gate_q),
   .ibf(ibf), .gate_out(gate_out)
);

// File: tb/a20_gate_ctl_tb.sv
module a20_gate_ctl_tb;

   logic        clk = 1'b0;
   logic        rst;
   logic        host_wr, host_aen;
   logic [15:0] host_addr;
   logic [7:0]  host_wdata;
   logic        fw_set_wr, fw_clr_wr, fw_gate_wr, fw_ibf_clr, p92_en;
   logic [7:0]  fw_gate_wdata;
   logic        gate_out, ibf;
   logic [7:0]  gate_rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference state
   bit m_arm, m_gate, m_ibf, m_sys;

   always #4 clk = ~clk;

   a20_gate_ctl u_dut (
      .clk(clk), .rst(rst), .host_wr(host_wr), .host_aen(host_aen),
      .host_addr(host_addr), .host_wdata(host_wdata),
      .fw_set_wr(fw_set_wr), .fw_clr_wr(fw_clr_wr), .fw_gate_wr(fw_gate_wr),
      .fw_gate_wdata(fw_gate_wdata), .fw_ibf_clr(fw_ibf_clr), .p92_en(p92_en),
      .gate_out(gate_out), .gate_rd_data(gate_rd_data), .ibf(ibf)
   );

   function automatic bit exp_gate();
      return m_gate | (p92_en & m_sys);
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      host_wr = 0; host_aen = 0; host_addr = 16'h0; host_wdata = 8'h0;
      fw_set_wr = 0; fw_clr_wr = 0; fw_gate_wr = 0; fw_gate_wdata = 8'h0; fw_ibf_clr = 0;
   endtask

   // model update from the requirements, applied at the edge
   task automatic model_edge();
      bit q, load, lval;
      q = host_wr && !host_aen;
      load = 0; lval = 0;
      if (rst) begin
         m_arm = 0; m_gate = 0; m_ibf = 0; m_sys = 0;
         return;
      end
      if (q && host_addr == 16'h64) begin
         if (host_wdata == 8'hD1) m_arm = 1;
         else if (host_wdata != 8'hFF && host_wdata != 8'hFE) m_arm = 0;
      end
      if (q && host_addr == 16'h60) begin
         if (m_arm) begin load = 1; lval = host_wdata[1]; end
         m_arm = 0;
      end
      if (q && host_addr == 16'h92) m_sys = host_wdata[1];
      if (fw_clr_wr) m_gate = 0;
      else if (fw_set_wr) m_gate = 1;
      else if (fw_gate_wr) m_gate = fw_gate_wdata[0];
      else if (load) m_gate = lval;
      if (q && host_addr == 16'h60) m_ibf = 1;
      else if (fw_ibf_clr) m_ibf = 0;
   endtask

   // one clock with current inputs, then check the outputs
   task automatic cycle(input string tag);
      @(posedge clk);
      model_edge();
      #1;
      chk({tag, " gate"}, {7'b0, gate_out}, {7'b0, exp_gate()});
      chk("R10 rd_data", gate_rd_data, {7'b0, exp_gate()});
      chk({tag, " ibf"}, {7'b0, ibf}, {7'b0, m_ibf});
      idle();
   endtask

   task automatic hw(input logic [15:0] a, input logic [7:0] d, input bit aen, input string tag);
      host_wr = 1; host_aen = aen; host_addr = a; host_wdata = d;
      cycle(tag);
   endtask

   initial begin
      #(8 * 20000);
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'hA20A20));
      idle(); p92_en = 0; rst = 1;
      repeat (3) begin @(posedge clk); model_edge(); #1; end
      rst = 0;
      chk("R1 gate", {7'b0, gate_out}, 8'h0);
      chk("R1 ibf", {7'b0, ibf}, 8'h0);
      chk("R1 rd", gate_rd_data, 8'h0);

      // R2: arm then data bit1 loads gate, later data ignored
      hw(16'h64, 8'hD1, 0, "R2 arm");
      hw(16'h60, 8'h02, 0, "R2 load");
      chk("R2 gate high", {7'b0, gate_out}, 8'h1);
      hw(16'h60, 8'h00, 0, "R2 consumed");
      chk("R2 still high", {7'b0, gate_out}, 8'h1);
      // R3: unarmed data write
      fw_clr_wr = 1; fw_set_wr = 1; fw_gate_wdata = 8'hFF; fw_gate_wr = 1;
      cycle("R7 clr wins");
      chk("R7 clr wins", {7'b0, gate_out}, 8'h0);
      hw(16'h60, 8'hFF, 0, "R3 unarmed");
      chk("R3 unarmed", {7'b0, gate_out}, 8'h0);
      // R5: null codes keep arm
      hw(16'h64, 8'hD1, 0, "R5 arm");
      hw(16'h64, 8'hFF, 0, "R5 ff");
      hw(16'h64, 8'hFE, 0, "R5 fe");
      hw(16'h60, 8'h02, 0, "R5 load");
      chk("R5 gate", {7'b0, gate_out}, 8'h1);
      // R4: other command cancels
      fw_clr_wr = 1; cycle("R7 clr");
      hw(16'h64, 8'hD1, 0, "R4 arm");
      hw(16'h64, 8'hAD, 0, "R4 cancel");
      hw(16'h60, 8'h02, 0, "R4 data");
      chk("R4 gate", {7'b0, gate_out}, 8'h0);
      // R6: aen high ignored
      hw(16'h64, 8'hD1, 1, "R6 arm aen");
      hw(16'h60, 8'h02, 0, "R6 data");
      chk("R6 gate", {7'b0, gate_out}, 8'h0);
      hw(16'h92, 8'h02, 1, "R6 sys aen");
      p92_en = 1; cycle("R6 sys");
      chk("R6 sys", {7'b0, gate_out}, 8'h0);
      // R9: system-control path
      hw(16'h92, 8'h02, 0, "R9 sys set");
      chk("R9 enabled", {7'b0, gate_out}, 8'h1);
      p92_en = 0; #1;
      chk("R9 disabled", {7'b0, gate_out}, 8'h0);
      hw(16'h92, 8'h00, 0, "R9 sys clr");
      // R7/R8: set with zero data, fw gate beats host load
      fw_set_wr = 1; fw_gate_wdata = 8'h00; cycle("R7 set");
      chk("R7 set", {7'b0, gate_out}, 8'h1);
      hw(16'h64, 8'hD1, 0, "R8 arm");
      fw_gate_wr = 1; fw_gate_wdata = 8'h00; host_wr = 1; host_addr = 16'h60; host_wdata = 8'h02;
      cycle("R8 precedence");
      chk("R8 precedence", {7'b0, gate_out}, 8'h0);
      // R11: set beats clear
      fw_ibf_clr = 1; host_wr = 1; host_addr = 16'h60; cycle("R11 both");
      chk("R11 both", {7'b0, ibf}, 8'h1);
      fw_ibf_clr = 1; cycle("R11 clr");
      chk("R11 clr", {7'b0, ibf}, 8'h0);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         int unsigned r;
         r = $urandom % 8;
         host_wr = ($urandom % 3) != 0;
         host_aen = ($urandom % 6) == 0;
         case (r)
            0, 1: host_addr = 16'h64;
            2, 3: host_addr = 16'h60;
            4: host_addr = 16'h92;
            default: host_addr = 16'($urandom);
         endcase
         case ($urandom % 5)
            0: host_wdata = 8'hD1;
            1: host_wdata = 8'hFF;
            2: host_wdata = 8'hFE;
            default: host_wdata = 8'($urandom);
         endcase
         fw_set_wr = ($urandom % 10) == 0;
         fw_clr_wr = ($urandom % 10) == 0;
         fw_gate_wr = ($urandom % 8) == 0;
         fw_gate_wdata = 8'($urandom);
         fw_ibf_clr = ($urandom % 4) == 0;
         if (($urandom % 16) == 0) p92_en = ~p92_en;
         cycle("R2 R7 R9 random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule